// File: doc/BRIEF.md
# Iterative Folded CORDIC Engine

This block evaluates circular CORDIC on one operand set at a time by looping a single shift-add micro-rotation stage under a small controller, rather than unrolling the iterations into a pipeline. A one-cycle start request loads a signed X/Y vector, a signed phase and a mode bit. The engine then spends one clock per micro-rotation. On pass i it shifts by i and adds or subtracts the arctangent of 2^-i, taken from a table that is computed at elaboration time. It signals completion with a single-cycle done strobe. It suits slow control, calibration and telemetry paths, where many clocks per result cost nothing and silicon area matters.

Two functions share the same hardware. In rotation mode the phase is driven to zero, so the vector comes out turned by the requested angle. In vectoring mode Y is driven to zero, so X becomes the vector length and the phase accumulates the vector's angle. Both results carry the fixed CORDIC gain (about 1.6468 for 16 passes). A caller that wants unit-scaled sine and cosine loads X already divided by that gain. During the load cycle, the operands are folded into the right half-plane by a 180-degree turn, so every angle on the circle converges.

Top module: `cordic_iter`

## Requirements
- R1: While reset is held and after it releases, busy_o and done_o are 0 and x_o, y_o, z_o are all 0.
- R2: A start_i seen high at a clock edge while busy_o is 0 is accepted. busy_o is 1 from that edge on. done_o rises exactly ITERS (16) edges after the accepting edge and stays high for one cycle only. busy_o is 0 in the cycle after done_o.
- R3: start_i while busy_o is 1, during the passes or during the done cycle, is ignored, together with the mode and operands offered with it. It changes neither the done timing nor the result, and it does not start another operation.
- R4: With mode_i = 0 (rotation), the result is x_o = K*(x*cos t - y*sin t) and y_o = K*(x*sin t + y*cos t), each within 6 LSB, where K is the product over i < ITERS of sqrt(1 + 2^-2i). The residual z_o lies within -2..2.
- R5: With mode_i = 1 (vectoring), x_o = K*sqrt(x^2 + y^2) within 4 LSB and |y_o| <= 5. z_o equals z_i plus atan2(y, x), modulo one turn, within 4 units.
- R6: The full circle is covered. Rotation phases beyond +/-90 degrees (including exactly +90 and -180) and vectoring inputs with x < 0 meet the accuracy of R4 and R5.
- R7: x_o, y_o and z_o do not change from the done cycle until the next accepted start, whatever the inputs do.
- R8: Encodings. z_i and z_o are two's complement with 2^ANG_W units per turn, so -2^(ANG_W-1) is -180 degrees and 2^(ANG_W-2) is +90 degrees. x_i and y_i are DATA_W-bit two's complement, including full scale -2^(DATA_W-1). x_o and y_o are DATA_W+2 bits wide at the same LSB weight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin an operation; honoured only while idle |
| mode_i | input | 1 | 0 = rotation, 1 = vectoring |
| x_i | input | DATA_W | Initial X, signed |
| y_i | input | DATA_W | Initial Y, signed |
| z_i | input | ANG_W | Initial phase, signed, full turn = 2^ANG_W |
| busy_o | output | 1 | High from acceptance through the done cycle |
| done_o | output | 1 | One-cycle completion strobe |
| x_o | output | DATA_W+2 | Final X, signed, gain included |
| y_o | output | DATA_W+2 | Final Y, signed, gain included |
| z_o | output | ANG_W | Final phase, signed |

## Verification
The hardest state to reach from the ports is a start request that arrives while the engine is mid-loop or sitting in its done cycle. It has to land at a known pass count and carry operands and a mode that would visibly alter the answer if it were taken. The bench reaches this with a hand-timed sequence. It pulses start with conflicting inputs at pass five and again in the done cycle. It then confirms that the latency, the first result and the idle state all survive. The quadrant fold is driven through sweeps across the whole phase circle and all vector directions, plus the exact +/-90 and 180 degree boundaries and full-scale operands. Each expected value is computed in floating point.

// File: rtl/cordic_iter_pkg.sv
`timescale 1ns/1ps
package cordic_iter_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } cordic_state_e;

   typedef enum logic {
      MODE_ROTATE = 1'b0,
      MODE_VECTOR = 1'b1
   } cordic_mode_e;

   localparam real TWO_PI = 6.283185307179586;

   // Micro-rotation angle for pass idx, in units of 2^bits per full turn, rounded.
   function automatic int atan_code(input int idx, input int bits);
      real t;
      real a;
      t = 1.0 / (2.0 ** idx);
      a = $atan(t) / TWO_PI * (2.0 ** bits);
      return $rtoi(a + 0.5);
   endfunction

endpackage

// File: rtl/cordic_iter_ctrl.sv
`timescale 1ns/1ps
module cordic_iter_ctrl
   import cordic_iter_pkg::*;
#(
   parameter int ITERS = 16,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   output logic             load_o,
   output logic             step_o,
   output logic [CNT_W-1:0] iter_o,
   output logic             busy_o,
   output logic             done_o
);

   localparam logic [CNT_W-1:0] LAST_PASS = CNT_W'(ITERS - 1);

   cordic_state_e    state_q;
   logic [CNT_W-1:0] iter_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         iter_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_RUN;
                  iter_q  <= '0;
               end
            end
            ST_RUN: begin
               if (iter_q == LAST_PASS) begin
                  state_q <= ST_DONE;
               end else begin
                  iter_q <= iter_q + CNT_W'(1);
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign load_o = (state_q == ST_IDLE) && start_i;
   assign step_o = (state_q == ST_RUN);
   assign iter_o = iter_q;
   assign busy_o = (state_q != ST_IDLE);
   assign done_o = (state_q == ST_DONE);

   assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && step_o && iter_q == '0));

   assert_run_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_o && iter_q == LAST_PASS) |=> (done_o && busy_o));

   // R3: a start seen mid-run neither restarts nor skips the pass sequence
   assert_pass_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_o && iter_q != LAST_PASS) |=> (step_o && iter_q == CNT_W'($past(iter_q) + CNT_W'(1))));

   assert_done_to_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);

endmodule

// File: rtl/cordic_iter_atan_rom.sv
`timescale 1ns/1ps
module cordic_iter_atan_rom
   import cordic_iter_pkg::*;
#(
   parameter int ITERS = 16,
   parameter int ZW    = 20,
   parameter int CNT_W = 4
) (
   input  logic        [CNT_W-1:0] idx_i,
   output logic signed [ZW-1:0]    angle_o
);

   if (ZW > 31) begin : g_bad_zw
      $error("cordic_iter_atan_rom: ZW must not exceed 31");
   end

   logic signed [ZW-1:0] table_w [ITERS];

   for (genvar g = 0; g < ITERS; g++) begin : g_entry
      localparam int CODE = atan_code(g, ZW);
      assign table_w[g] = CODE[ZW-1:0];
   end

   assign angle_o = table_w[idx_i];

endmodule

// File: rtl/cordic_iter_stage.sv
`timescale 1ns/1ps
module cordic_iter_stage #(
   parameter int WORK_W    = 22,
   parameter int ZW        = 20,
   parameter int CNT_W     = 4,
   parameter bit LOG_SHIFT = 1'b1
) (
   input  logic               vector_i,
   input  logic signed [WORK_W-1:0] x_i,
   input  logic signed [WORK_W-1:0] y_i,
   input  logic signed [ZW-1:0]     z_i,
   input  logic        [CNT_W-1:0]  shift_i,
   input  logic signed [ZW-1:0]     angle_i,
   output logic signed [WORK_W-1:0] x_o,
   output logic signed [WORK_W-1:0] y_o,
   output logic signed [ZW-1:0]     z_o
);

   logic signed [WORK_W-1:0] x_sh;
   logic signed [WORK_W-1:0] y_sh;
   logic                     turn_ccw;

   if (LOG_SHIFT) begin : g_log_shift
      logic signed [WORK_W-1:0] xs [CNT_W+1];
      logic signed [WORK_W-1:0] ys [CNT_W+1];
      assign xs[0] = x_i;
      assign ys[0] = y_i;
      for (genvar k = 0; k < CNT_W; k++) begin : g_level
         assign xs[k+1] = shift_i[k] ? (xs[k] >>> (2 ** k)) : xs[k];
         assign ys[k+1] = shift_i[k] ? (ys[k] >>> (2 ** k)) : ys[k];
      end
      assign x_sh = xs[CNT_W];
      assign y_sh = ys[CNT_W];
   end else begin : g_flat_shift
      assign x_sh = x_i >>> shift_i;
      assign y_sh = y_i >>> shift_i;
   end

   // Rotation drives phase to zero; vectoring drives Y to zero.
   assign turn_ccw = vector_i ? y_i[WORK_W-1] : ~z_i[ZW-1];

   always_comb begin
      if (turn_ccw) begin
         x_o = x_i - y_sh;
         y_o = y_i + x_sh;
         z_o = z_i - angle_i;
      end else begin
         x_o = x_i + y_sh;
         y_o = y_i - x_sh;
         z_o = z_i + angle_i;
      end
   end

endmodule

// File: rtl/cordic_iter.sv
`timescale 1ns/1ps
module cordic_iter
   import cordic_iter_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ANG_W      = 16,
   parameter int ITERS      = 16,
   parameter int GUARD_W    = 2,
   parameter int FRAC_W     = 4,
   parameter int ANG_FRAC_W = 4,
   parameter bit LOG_SHIFT  = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start_i,
   input  logic                          mode_i,
   input  logic signed [DATA_W-1:0]      x_i,
   input  logic signed [DATA_W-1:0]      y_i,
   input  logic signed [ANG_W-1:0]       z_i,
   output logic                          busy_o,
   output logic                          done_o,
   output logic signed [DATA_W+GUARD_W-1:0] x_o,
   output logic signed [DATA_W+GUARD_W-1:0] y_o,
   output logic signed [ANG_W-1:0]       z_o
);

   localparam int OUT_W  = DATA_W + GUARD_W;
   localparam int WORK_W = OUT_W + FRAC_W;
   localparam int ZW     = ANG_W + ANG_FRAC_W;
   localparam int CNT_W  = (ITERS > 1) ? $clog2(ITERS) : 1;

   if (DATA_W < 4)          begin : g_chk_data  $error("cordic_iter: DATA_W too small"); end
   if (ANG_W < 4)           begin : g_chk_ang   $error("cordic_iter: ANG_W too small"); end
   if (GUARD_W < 2)         begin : g_chk_guard $error("cordic_iter: GUARD_W must cover gain and fold"); end
   if (ITERS < 2)           begin : g_chk_it_lo $error("cordic_iter: ITERS must be at least 2"); end
   if (ITERS > WORK_W - 1)  begin : g_chk_it_hi $error("cordic_iter: ITERS exceeds datapath width"); end
   if (ZW > 31)             begin : g_chk_zw    $error("cordic_iter: phase path wider than 31 bits"); end

   logic                     load_w;
   logic                     step_w;
   logic [CNT_W-1:0]         iter_w;

   logic signed [WORK_W-1:0] x_q, y_q;
   logic signed [ZW-1:0]     z_q;
   cordic_mode_e             mode_q;

   logic signed [WORK_W-1:0] x_ext, y_ext;
   logic signed [ZW-1:0]     z_ext;
   logic                     fold_w;
   logic signed [WORK_W-1:0] x_ld, y_ld;
   logic signed [ZW-1:0]     z_ld;

   logic signed [ZW-1:0]     step_angle;
   logic signed [WORK_W-1:0] x_nx, y_nx;
   logic signed [ZW-1:0]     z_nx;

   cordic_iter_ctrl #(
      .ITERS (ITERS),
      .CNT_W (CNT_W)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .load_o  (load_w),
      .step_o  (step_w),
      .iter_o  (iter_w),
      .busy_o  (busy_o),
      .done_o  (done_o)
   );

   cordic_iter_atan_rom #(
      .ITERS (ITERS),
      .ZW    (ZW),
      .CNT_W (CNT_W)
   ) u_rom (
      .idx_i   (iter_w),
      .angle_o (step_angle)
   );

   cordic_iter_stage #(
      .WORK_W    (WORK_W),
      .ZW        (ZW),
      .CNT_W     (CNT_W),
      .LOG_SHIFT (LOG_SHIFT)
   ) u_stage (
      .vector_i (mode_q == MODE_VECTOR),
      .x_i      (x_q),
      .y_i      (y_q),
      .z_i      (z_q),
      .shift_i  (iter_w),
      .angle_i  (step_angle),
      .x_o      (x_nx),
      .y_o      (y_nx),
      .z_o      (z_nx)
   );

   // Load path: widen, then fold into the convergent half-plane by a 180 degree turn.
   assign x_ext = $signed({{GUARD_W{x_i[DATA_W-1]}}, x_i, {FRAC_W{1'b0}}});
   assign y_ext = $signed({{GUARD_W{y_i[DATA_W-1]}}, y_i, {FRAC_W{1'b0}}});
   assign z_ext = $signed({z_i, {ANG_FRAC_W{1'b0}}});

   always_comb begin
      if (mode_i) begin
         fold_w = x_i[DATA_W-1];
      end else begin
         fold_w = z_i[ANG_W-1] ^ z_i[ANG_W-2];
      end
      if (fold_w) begin
         x_ld = -x_ext;
         y_ld = -y_ext;
         z_ld = $signed({~z_ext[ZW-1], z_ext[ZW-2:0]});
      end else begin
         x_ld = x_ext;
         y_ld = y_ext;
         z_ld = z_ext;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q    <= '0;
         y_q    <= '0;
         z_q    <= '0;
         mode_q <= MODE_ROTATE;
      end else if (load_w) begin
         x_q    <= x_ld;
         y_q    <= y_ld;
         z_q    <= z_ld;
         mode_q <= cordic_mode_e'(mode_i);
      end else if (step_w) begin
         x_q <= x_nx;
         y_q <= y_nx;
         z_q <= z_nx;
      end
   end

   assign x_o = x_q[WORK_W-1:FRAC_W];
   assign y_o = y_q[WORK_W-1:FRAC_W];
   assign z_o = z_q[ZW-1:ANG_FRAC_W];

   assert_xpos_in_vectoring_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step_w && mode_q == MODE_VECTOR) |-> !x_q[WORK_W-1]);

   assert_fold_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_w && iter_w == '0 && mode_q == MODE_ROTATE) |-> (z_q[ZW-1] == z_q[ZW-2]));

   assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_w && !load_w) |=> ($stable(x_q) && $stable(y_q) && $stable(z_q)));

   assert_rot_residual_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && mode_q == MODE_ROTATE) |-> (z_o >= -2 && z_o <= 2));

endmodule

// File: tb/test_cordic_iter.sv
`timescale 1ns/1ps
module test_cordic_iter;

   localparam int  DW  = 16;
   localparam int  AW  = 16;
   localparam int  N   = 16;
   localparam int  OW  = DW + 2;
   localparam real TAU = 6.283185307179586;
   localparam real TURN = 65536.0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic mode_i = 1'b0;
   logic signed [DW-1:0] x_i = '0;
   logic signed [DW-1:0] y_i = '0;
   logic signed [AW-1:0] z_i = '0;
   logic busy_o, done_o;
   logic signed [OW-1:0] x_o, y_o;
   logic signed [AW-1:0] z_o;

   int  checks = 0;
   int  fails  = 0;
   real gain;

   always #2.5 clk = ~clk;

   cordic_iter i_cordic_iter (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .mode_i  (mode_i),
      .x_i     (x_i),
      .y_i     (y_i),
      .z_i     (z_i),
      .busy_o  (busy_o),
      .done_o  (done_o),
      .x_o     (x_o),
      .y_o     (y_o),
      .z_o     (z_o)
   );

   function automatic real rabs(input real v);
      return (v < 0.0) ? -v : v;
   endfunction

   function automatic int wrap16(input int v);
      int m;
      m = (v + 32768) % 65536;
      if (m < 0) m += 65536;
      return m - 32768;
   endfunction

   task automatic check(input bit ok, input string msg);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s", msg);
      end
   endtask

   // Runs one operation; checks latency and the single-cycle strobe (R2).
   task automatic run_op(input bit md, input int xa, input int ya, input int za,
                         output int xo, output int yo, output int zo);
      int lat;
      int guard;
      @(negedge clk);
      guard = 0;
      while (busy_o && guard < 100) begin @(negedge clk); guard++; end
      mode_i  = md;
      x_i     = DW'(xa);
      y_i     = DW'(ya);
      z_i     = AW'(za);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      lat = 0;
      while (!done_o && lat < 100) begin @(negedge clk); lat++; end
      xo = int'(x_o);
      yo = int'(y_o);
      zo = int'(z_o);
      check(lat == N, $sformatf("R2 latency actual=%0d expected=%0d", lat, N));
      @(negedge clk);
      check(!done_o && !busy_o, $sformatf("R2 strobe after done: done=%0b busy=%0b expected 0 0",
                                          done_o, busy_o));
   endtask

   task automatic check_rot(input int xa, input int ya, input int za, input string req);
      int xo, yo, zo;
      real th, ex, ey;
      run_op(1'b0, xa, ya, za, xo, yo, zo);
      th = real'(za) * TAU / TURN;
      ex = gain * (real'(xa) * $cos(th) - real'(ya) * $sin(th));
      ey = gain * (real'(xa) * $sin(th) + real'(ya) * $cos(th));
      check(rabs(real'(xo) - ex) <= 6.0 && rabs(real'(yo) - ey) <= 6.0 && zo >= -2 && zo <= 2,
            $sformatf("%s rotate x=%0d y=%0d z=%0d: actual (%0d,%0d,%0d) expected (%0.1f,%0.1f,0)",
                      req, xa, ya, za, xo, yo, zo, ex, ey));
   endtask

   task automatic check_vec(input int xa, input int ya, input int za, input string req);
      int xo, yo, zo;
      real ex, ez, dz;
      run_op(1'b1, xa, ya, za, xo, yo, zo);
      ex = gain * $sqrt(real'(xa) * real'(xa) + real'(ya) * real'(ya));
      ez = real'(za) + $atan2(real'(ya), real'(xa)) * TURN / TAU;
      dz = real'(zo) - ez;
      while (dz > 32768.0)  dz -= TURN;
      while (dz < -32768.0) dz += TURN;
      check(rabs(real'(xo) - ex) <= 4.0 && yo >= -5 && yo <= 5 && rabs(dz) <= 4.0,
            $sformatf("%s vector x=%0d y=%0d z=%0d: actual (%0d,%0d,%0d) expected (%0.1f,0,%0.1f)",
                      req, xa, ya, za, xo, yo, zo, ex, ez));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int xo, yo, zo;
      int sx, sy, sz;
      int lat;
      bit stable_ok;

      gain = 1.0;
      for (int i = 0; i < N; i++) gain = gain * $sqrt(1.0 + 1.0 / (4.0 ** i));

      // R1: reset state
      repeat (3) @(negedge clk);
      check(!busy_o && !done_o && x_o == 0 && y_o == 0 && z_o == 0,
            $sformatf("R1 during reset busy=%0b done=%0b x=%0d y=%0d z=%0d expected all 0",
                      busy_o, done_o, x_o, y_o, z_o));
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy_o && !done_o && x_o == 0 && y_o == 0 && z_o == 0,
            $sformatf("R1 after release busy=%0b done=%0b x=%0d expected 0", busy_o, done_o, x_o));

      // Directed rotation points
      check_rot(10000, 0, 0, "R4");
      check_rot(10000, 0, 8192, "R4");
      check_rot(10000, 0, -32768, "R8");
      check_rot(0, 10000, 16384, "R6");
      check_rot(12000, 3000, -16384, "R4");
      check_rot(12000, 3000, 16383, "R4");
      check_rot(12000, 3000, -16385, "R6");
      check_rot(-9000, 14000, 32767, "R6");
      check_rot(-32768, -32768, 8192, "R8");
      check_rot(32767, -32768, -24000, "R8");

      // Directed vectoring points
      check_vec(20000, -1, 100, "R5");
      check_vec(0, 15000, 0, "R5");
      check_vec(-20000, 0, 0, "R6");
      check_vec(-20000, 1, -5000, "R6");
      check_vec(-32768, -32768, 0, "R8");
      check_vec(32767, 32767, 30000, "R8");

      // Rotation sweep over the phase circle
      for (int k = 0; k < 256; k++) begin
         int za, xa, ya;
         za = wrap16(k * 256 - 32768 + 37);
         case (k % 3)
            0: begin xa = 20000;  ya = 0;     end
            1: begin xa = 12000;  ya = -9000; end
            default: begin xa = -7000; ya = 15000; end
         endcase
         if (za >= 16384 || za < -16384) check_rot(xa, ya, za, "R6");
         else                            check_rot(xa, ya, za, "R4");
      end

      // Vectoring sweep over all directions at two radii
      for (int k = 0; k < 128; k++) begin
         for (int r = 0; r < 2; r++) begin
            real ang, rad;
            int  xa, ya, za;
            ang = real'(k) * TAU / 128.0 + 0.01;
            rad = (r == 0) ? 25000.0 : 6000.0;
            xa  = $rtoi(rad * $cos(ang) + ((rad * $cos(ang)) < 0.0 ? -0.5 : 0.5));
            ya  = $rtoi(rad * $sin(ang) + ((rad * $sin(ang)) < 0.0 ? -0.5 : 0.5));
            za  = wrap16(k * 311 - 20000);
            if (xa < 0) check_vec(xa, ya, za, "R6");
            else        check_vec(xa, ya, za, "R5");
         end
      end

      // R3: start pulses while busy, mid-run and in the done cycle
      @(negedge clk);
      while (busy_o) @(negedge clk);
      mode_i = 1'b0; x_i = 16'sd15000; y_i = 16'sd0; z_i = 16'sd4096;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      lat = 0;
      while (!done_o && lat < 100) begin
         @(negedge clk);
         lat++;
         if (lat == 5) begin
            mode_i = 1'b1; x_i = -16'sd3000; y_i = 16'sd7000; z_i = -16'sd12000;
            start_i = 1'b1;
         end else if (lat == 6) begin
            start_i = 1'b0;
         end
      end
      check(lat == N, $sformatf("R3 latency with mid-run start actual=%0d expected=%0d", lat, N));
      begin
         real ex, ey;
         ex = gain * 15000.0 * $cos(4096.0 * TAU / TURN);
         ey = gain * 15000.0 * $sin(4096.0 * TAU / TURN);
         sx = int'(x_o); sy = int'(y_o); sz = int'(z_o);
         check(rabs(real'(sx) - ex) <= 6.0 && rabs(real'(sy) - ey) <= 6.0 && sz >= -2 && sz <= 2,
               $sformatf("R3 result after ignored start actual (%0d,%0d,%0d) expected (%0.1f,%0.1f,0)",
                         sx, sy, sz, ex, ey));
      end
      // done cycle: offer a start, withdraw it the next cycle
      mode_i = 1'b1; x_i = 16'sd100; y_i = 16'sd200; z_i = 16'sd300;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      stable_ok = 1'b1;
      for (int c = 0; c < 4; c++) begin
         if (busy_o || done_o) stable_ok = 1'b0;
         @(negedge clk);
      end
      check(stable_ok, $sformatf("R3 start in done cycle was taken: busy=%0b done=%0b expected 0 0",
                                 busy_o, done_o));

      // R7: results hold while inputs move without start
      stable_ok = 1'b1;
      for (int c = 0; c < 6; c++) begin
         x_i = DW'(c * 4111 - 9000);
         y_i = DW'(-c * 2222);
         z_i = AW'(c * 9999);
         mode_i = c[0];
         @(negedge clk);
         if (int'(x_o) != sx || int'(y_o) != sy || int'(z_o) != sz) stable_ok = 1'b0;
      end
      check(stable_ok, $sformatf("R7 outputs moved: actual (%0d,%0d,%0d) expected (%0d,%0d,%0d)",
                                 x_o, y_o, z_o, sx, sy, sz));

      // R7 again right after a vectoring result
      run_op(1'b1, -12000, 5000, 777, xo, yo, zo);
      stable_ok = 1'b1;
      for (int c = 0; c < 5; c++) begin
         x_i = DW'(c * 1000);
         @(negedge clk);
         if (int'(x_o) != xo || int'(y_o) != yo || int'(z_o) != zo) stable_ok = 1'b0;
      end
      check(stable_ok, $sformatf("R7 vectoring result moved: actual (%0d,%0d,%0d) expected (%0d,%0d,%0d)",
                                 x_o, y_o, z_o, xo, yo, zo));

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule